// File: doc/BRIEF.md
# Byte/Word Result Read Port

This block places a held 12-bit conversion result onto a shared three-state data bus. A host can read the result in one of two ways. It can take all twelve bits in one access. It can also take two left-justified bytes over an 8-bit bus. The upper byte holds bits 11..4. The lower byte carries bits 3..0 in its upper half and zeros in its lower half. The bus lines are split into three 4-bit lanes. Each lane has its own data value and its own drive-enable output, and pad cells outside the block use these to build the real three-state drivers.

A read is allowed only when four things hold at once: the read/convert line is high, the converter is idle, the chip enable is high and the active-low chip select is low. A word/byte select input chooses between word and byte access. In byte access, the address bit picks which byte is presented. The result is reached through a registered selection stage. Whenever the presented selection changes, or drive is released, the bus is held fully released for at least a set number of clocks before any lane drives again. Two different groups of drivers therefore never overlap.

For stand-alone use, tie the chip enable and word select high and the chip select and address bit low. A single read/convert line then gates the whole 12-bit word.

Top module: `rdp_read_port`

## Requirements
- R1: While the active-low reset is asserted, all three lane enables are low and all bus data bits are 0.
- R2: A lane enable may be high in a cycle only if, at the previous clock edge, rd_mode was 1, busy was 0, chip_en was 1 and chip_sel_n was 0. If any of these fails at an edge, all enables are low after that edge.
- R3: In word access (word_mode = 1), nib_oe becomes 3'b111 and bus_data equals result. The value of byte_sel has no effect: toggling it while reading a word keeps nib_oe at 3'b111 with no released cycle.
- R4: In byte access with byte_sel = 0 (high byte), nib_oe is 3'b110 and bus_data[11:4] equals result[11:4].
- R5: In byte access with byte_sel = 1 (low byte), nib_oe is 3'b011, bus_data[7:4] is forced to 0 and bus_data[3:0] equals result[3:0].
- R6: nib_oe never changes directly from one nonzero value to a different nonzero value. A change of selection (high byte, low byte or word) gives GAP_CYCLES cycles (default 1) with nib_oe = 3'b000, and then the new enables.
- R7: Starting from a released bus with the gap already served, the enables appear at the first clock edge at which the read conditions hold.
- R8: With chip_en = 1, word_mode = 1, byte_sel = 0 and chip_sel_n = 0, the whole word is driven exactly while rd_mode is 1 and busy is 0, and busy going high during a read releases the bus at the next edge.
- R9: Lanes that are not enabled present data 0 (ZERO_IDLE = 1, the default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_mode | input | 1 | Read/convert line, 1 = read |
| busy | input | 1 | Conversion in progress, from the converter controller |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| word_mode | input | 1 | 1 = 12-bit word access, 0 = two-byte access |
| byte_sel | input | 1 | Byte address bit: 0 = high byte, 1 = low byte |
| result | input | 12 | Held conversion result |
| bus_data | output | 12 | Data toward the pad drivers, lane 2 = bits 11:8 |
| nib_oe | output | 3 | Per-lane drive enable, bit i enables bits 4i+3:4i |

## Verification
The result is read with two bit patterns whose nibbles are all different. This shows that each lane takes the right slice, and that the middle lane of the low byte is really forced to zero and is not left showing result bits. Each of the four read conditions is removed on its own, so a gate that ignores one term shows up. Byte-to-byte, word-to-byte and byte-to-word switches are run cycle by cycle to expose a missing or misplaced released cycle. Toggling the address bit during a word read shows whether it is wrongly ignored or wrongly obeyed.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

   typedef enum logic [1:0] {
      SEL_OFF  = 2'd0,
      SEL_WORD = 2'd1,
      SEL_HI   = 2'd2,
      SEL_LO   = 2'd3
   } sel_e;

   localparam int unsigned LANES = 3;

   // lane enable pattern for a selection, lane 2 = top nibble
   function automatic logic [LANES-1:0] lane_mask(input sel_e s);
      case (s)
         SEL_WORD: lane_mask = 3'b111;
         SEL_HI:   lane_mask = 3'b110;
         SEL_LO:   lane_mask = 3'b011;
         default:  lane_mask = 3'b000;
      endcase
   endfunction

endpackage

// File: rtl/rdp_decode.sv
module rdp_decode
   import rdp_pkg::*;
(
   input  logic rd_mode,
   input  logic busy,
   input  logic chip_en,
   input  logic chip_sel_n,
   input  logic word_mode,
   input  logic byte_sel,
   output logic gate_ok,
   output sel_e req
);

   always_comb begin
      gate_ok = rd_mode & ~busy & chip_en & ~chip_sel_n;
      if (!gate_ok)       req = SEL_OFF;
      else if (word_mode) req = SEL_WORD;
      else if (byte_sel)  req = SEL_LO;
      else                req = SEL_HI;
   end

endmodule

// File: rtl/rdp_bbm.sv
module rdp_bbm
   import rdp_pkg::*;
#(
   parameter int unsigned GAP_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  sel_e req,
   output sel_e cur
);

   localparam int unsigned CNT_W    = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(GAP_CYCLES - 1);

   sel_e             cur_q;
   logic [CNT_W-1:0] quiet_q;
   logic             gap_done;

   assign gap_done = (quiet_q >= CNT_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q   <= SEL_OFF;
         quiet_q <= CNT_FULL;
      end else if (cur_q != SEL_OFF) begin
         if (req != cur_q) begin
            cur_q   <= SEL_OFF;
            quiet_q <= '0;
         end
      end else if (gap_done) begin
         cur_q <= req;
      end else begin
         quiet_q <= quiet_q + 1'b1;
      end
   end

   assign cur = cur_q;

endmodule

// File: rtl/rdp_lanes.sv
module rdp_lanes
   import rdp_pkg::*;
#(
   parameter int unsigned NIB_W     = 4,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input  sel_e                    cur,
   input  logic [LANES*NIB_W-1:0]  result,
   output logic [LANES*NIB_W-1:0]  bus_data,
   output logic [LANES-1:0]        nib_oe
);

   logic [LANES-1:0] en;
   logic             mid_zero;

   assign en       = lane_mask(cur);
   assign mid_zero = (cur == SEL_LO);
   assign nib_oe   = en;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [NIB_W-1:0] slice;
      logic             force0;
      assign slice  = result[i*NIB_W +: NIB_W];
      assign force0 = (i == 1) ? mid_zero : 1'b0;
      if (ZERO_IDLE) begin : g_zero
         assign bus_data[i*NIB_W +: NIB_W] = (en[i] && !force0) ? slice : '0;
      end else begin : g_raw
         assign bus_data[i*NIB_W +: NIB_W] = force0 ? '0 : slice;
      end
   end

endmodule

// File: rtl/rdp_read_port.sv
module rdp_read_port
   import rdp_pkg::*;
#(
   parameter int unsigned NIB_W      = 4,
   parameter int unsigned GAP_CYCLES = 1,
   parameter bit          ZERO_IDLE  = 1'b1,
   localparam int unsigned DATA_W    = LANES * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_mode,
   input  logic              busy,
   input  logic              chip_en,
   input  logic              chip_sel_n,
   input  logic              word_mode,
   input  logic              byte_sel,
   input  logic [DATA_W-1:0] result,
   output logic [DATA_W-1:0] bus_data,
   output logic [LANES-1:0]  nib_oe
);

   if (NIB_W < 1) begin : g_bad_nib
      $error("rdp_read_port: NIB_W must be at least 1");
   end
   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("rdp_read_port: GAP_CYCLES must be at least 1");
   end

   logic gate_ok;
   sel_e req;
   sel_e cur;

   rdp_decode u_dec (
      .rd_mode    (rd_mode),
      .busy       (busy),
      .chip_en    (chip_en),
      .chip_sel_n (chip_sel_n),
      .word_mode  (word_mode),
      .byte_sel   (byte_sel),
      .gate_ok    (gate_ok),
      .req        (req)
   );

   rdp_bbm #(.GAP_CYCLES(GAP_CYCLES)) u_bbm (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .cur   (cur)
   );

   rdp_lanes #(.NIB_W(NIB_W), .ZERO_IDLE(ZERO_IDLE)) u_lanes (
      .cur      (cur),
      .result   (result),
      .bus_data (bus_data),
      .nib_oe   (nib_oe)
   );

endmodule

// File: rtl/rdp_read_port_chk.sv
module rdp_read_port_chk #(
   parameter int unsigned NIB_W = 4,
   localparam int unsigned DW   = 3 * NIB_W
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_mode,
   input logic          busy,
   input logic          chip_en,
   input logic          chip_sel_n,
   input logic          word_mode,
   input logic          byte_sel,
   input logic [DW-1:0] result,
   input logic [DW-1:0] bus_data,
   input logic [2:0]    nib_oe
);

   logic ok_now;
   assign ok_now = rd_mode && !busy && chip_en && !chip_sel_n;

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (nib_oe == 3'b000 && bus_data == '0);
      end
   end

   // R2
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ok_now) |-> nib_oe == 3'b000);

   // R3
   word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ok_now && word_mode) && nib_oe != 3'b000) |-> nib_oe == 3'b111);

   // R4
   high_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ok_now && !word_mode && !byte_sel) && nib_oe != 3'b000)
         |-> nib_oe == 3'b110);

   // R5
   low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nib_oe == 3'b011 |-> (bus_data[2*NIB_W-1:NIB_W] == '0 &&
                            bus_data[NIB_W-1:0] == result[NIB_W-1:0]));

   // R6
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nib_oe != 3'b000 && $past(nib_oe) != 3'b000) |-> nib_oe == $past(nib_oe));

   // R9
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nib_oe == 3'b000 |-> bus_data == '0);

endmodule

bind rdp_read_port rdp_read_port_chk #(.NIB_W(NIB_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_mode    (rd_mode),
   .busy       (busy),
   .chip_en    (chip_en),
   .chip_sel_n (chip_sel_n),
   .word_mode  (word_mode),
   .byte_sel   (byte_sel),
   .result     (result),
   .bus_data   (bus_data),
   .nib_oe     (nib_oe)
);

// File: tb/sim_rdp_read_port.sv
`timescale 1ns/1ps
module sim_rdp_read_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_mode = 1'b0, busy = 1'b0, chip_en = 1'b0, chip_sel_n = 1'b1;
   logic        word_mode = 1'b1, byte_sel = 1'b0;
   logic [11:0] result = 12'h000;
   logic [11:0] bus_data;
   logic [2:0]  nib_oe;

   int n_chk = 0;
   int n_bad = 0;
   int overlap_viol = 0;
   bit done = 1'b0;
   logic [2:0] prev_oe = 3'b000;

   always #2.5 clk = ~clk;

   rdp_read_port u0 (
      .clk(clk), .rst_n(rst_n), .rd_mode(rd_mode), .busy(busy),
      .chip_en(chip_en), .chip_sel_n(chip_sel_n), .word_mode(word_mode),
      .byte_sel(byte_sel), .result(result), .bus_data(bus_data), .nib_oe(nib_oe)
   );

   task automatic check(input bit ok, input string tag, input logic [15:0] act,
                        input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_oe(input logic [2:0] e, input string tag);
      check(nib_oe == e, tag, {13'd0, nib_oe}, {13'd0, e});
   endtask

   task automatic open_read(input bit w, input bit a);
      rd_mode = 1; busy = 0; chip_en = 1; chip_sel_n = 0;
      word_mode = w; byte_sel = a;
   endtask

   task automatic release_bus();
      rd_mode = 0;
      step(); step();
   endtask

   // R6 monitor: never jump between two nonzero enable patterns
   always @(negedge clk) begin
      if (rst_n) begin
         if (nib_oe != 3'b000 && prev_oe != 3'b000 && nib_oe != prev_oe)
            overlap_viol++;
      end
      prev_oe <= nib_oe;
   end

   task automatic t_reset();
      #1;
      check(nib_oe == 3'b000, "R1 enables in reset", {13'd0, nib_oe}, 16'h0);
      check(bus_data == 12'h000, "R1 data in reset", {4'd0, bus_data}, 16'h0);
   endtask

   task automatic t_word();
      result = 12'hA5C;
      open_read(1, 0);
      step();
      expect_oe(3'b111, "R3/R7 word enables at first edge");
      check(bus_data == 12'hA5C, "R3 word data", {4'd0, bus_data}, 16'h0A5C);
      byte_sel = 1;
      step();
      expect_oe(3'b111, "R3 byte_sel ignored in word");
      byte_sel = 0;
      step();
      expect_oe(3'b111, "R3 byte_sel toggled back");
      result = 12'h3F1;
      #1;
      check(bus_data == 12'h3F1, "R3 word data second pattern", {4'd0, bus_data}, 16'h03F1);
      release_bus();
   endtask

   task automatic t_gate();
      result = 12'h6B2;
      for (int k = 0; k < 4; k++) begin
         open_read(1, 0);
         case (k)
            0: rd_mode = 0;
            1: busy = 1;
            2: chip_en = 0;
            default: chip_sel_n = 1;
         endcase
         step(); step();
         expect_oe(3'b000, $sformatf("R2 gate term %0d missing", k));
         check(bus_data == 12'h000, "R9 idle lanes zero", {4'd0, bus_data}, 16'h0);
         open_read(1, 0);
         step();
         expect_oe(3'b111, "R7 enable after gate restored");
         release_bus();
      end
   endtask

   task automatic t_bytes();
      result = 12'hC7E;
      open_read(0, 0);
      step();
      expect_oe(3'b110, "R4 high byte enables");
      check(bus_data[11:4] == 8'hC7, "R4 high byte data", {8'd0, bus_data[11:4]}, 16'h00C7);
      byte_sel = 1;
      step();
      expect_oe(3'b000, "R6 gap high->low");
      step();
      expect_oe(3'b011, "R5 low byte enables");
      check(bus_data[7:0] == 8'h0E, "R5 low byte data", {8'd0, bus_data[7:0]}, 16'h000E);
      result = 12'h5D9;
      #1;
      check(bus_data[7:0] == 8'h09, "R5 low byte second pattern", {8'd0, bus_data[7:0]}, 16'h0009);
      byte_sel = 0;
      step();
      expect_oe(3'b000, "R6 gap low->high");
      step();
      expect_oe(3'b110, "R4 high byte after gap");
      check(bus_data[11:4] == 8'h5D, "R4 high byte second pattern", {8'd0, bus_data[11:4]}, 16'h005D);
      word_mode = 1;
      step();
      expect_oe(3'b000, "R6 gap byte->word");
      step();
      expect_oe(3'b111, "R3 word after gap");
      word_mode = 0; byte_sel = 1;
      step();
      expect_oe(3'b000, "R6 gap word->low");
      step();
      expect_oe(3'b011, "R5 low after gap");
      release_bus();
   endtask

   task automatic t_standalone();
      result = 12'h2E4;
      chip_en = 1; word_mode = 1; byte_sel = 0; chip_sel_n = 0;
      rd_mode = 0; busy = 0;
      step();
      expect_oe(3'b000, "R8 stand-alone rd_mode low");
      rd_mode = 1;
      step();
      expect_oe(3'b111, "R8 stand-alone read");
      check(bus_data == 12'h2E4, "R8 stand-alone data", {4'd0, bus_data}, 16'h02E4);
      busy = 1;
      step();
      expect_oe(3'b000, "R8 busy releases bus");
      busy = 0;
      step();
      expect_oe(3'b111, "R8 read after busy clears");
      release_bus();
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      t_reset();
      step(); step();
      rst_n = 1;
      step();
      t_word();
      t_gate();
      t_bytes();
      t_standalone();
      check(overlap_viol == 0, "R6 no direct enable switch", overlap_viol[15:0], 16'h0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule